// File: doc/BRIEF.md
# Addressed Serial Level-Register Loader

This block is the digital front end of an eight-channel level generator. A host selects it by pulling an active-low select line low, then shifts in an 11-bit command over a serial clock and data line. The command carries a 3-bit channel number followed by an 8-bit level, each sent most significant bit first. When the select line returns high, the level is written into the register of the addressed channel. The eight register values drive eight converter channels through a flat output bus.

The serial clock and select lines are not used as clocks. They are brought into the system clock domain through two-flop synchronizers, and their edges are detected there. A hardware preset loads every channel with the half-scale code. A power-down input forces the channel outputs to zero while the stored levels are kept, and the levels reappear when power-down is released. A one-cycle update strobe and the updated channel number are provided for checking.

Top module: `ser_dac_load`

## Requirements
- R1: A data bit is captured on each rising edge of `sclk` while `cs_n` is low. The frame is shifted in MSB first: frame bits [10:8] form the channel number and bits [7:0] form the level.
- R2: A channel number k writes the level into channel k only. Channel k appears on `levels[8k+7:8k]`, and the other channels keep their values.
- R3: When more than 11 bits are shifted in before `cs_n` rises, only the last 11 bits are decoded.
- R4: A frame of fewer than 11 bits, including a frame of zero bits, changes no channel and produces no strobe.
- R5: Rising edges of `sclk` while `cs_n` is high are ignored. Raising `cs_n` clears any partial frame, so the next frame starts from an empty shift register.
- R6: A channel is written only after the rising edge of `cs_n`. A complete 11-bit frame with `cs_n` still low changes no output.
- R7: Both `rst_n` low and a `mid_rst` pulse set all eight channels to 8'h80. `mid_rst` takes priority over a write that completes in the same cycle.
- R8: While `shdn` is high, `levels` reads all zeros and `shdn_o` is high one clock later. After `shdn` is released, the stored levels, including any loaded during power-down, reappear.
- R9: Each channel update produces `wr_stb` for exactly one clock, with `wr_addr` giving the channel that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; presets channels to half scale |
| mid_rst | input | 1 | Synchronous preset of all channels to half scale |
| shdn | input | 1 | Power-down request |
| sclk | input | 1 | Serial clock, asynchronous, at most a quarter of the `clk` rate |
| cs_n | input | 1 | Active-low select |
| sdi | input | 1 | Serial data |
| levels | output | 64 | Eight 8-bit channel levels, channel k at bits [8k+7:8k] |
| shdn_o | output | 1 | Power-down indication |
| wr_stb | output | 1 | One-cycle channel update strobe |
| wr_addr | output | 3 | Channel number of the latest update |

## Verification
The assertions check four properties on every cycle:
- The stored levels move only together with an update strobe or one cycle after a preset.
- A preset always leaves every channel at half scale.
- The strobe never lasts two cycles.
- The outputs read zero whenever power-down is indicated.

Frame decoding can only be shown by the bench's scenarios, because it depends on serial history. This covers bit order, channel selection, keeping the last 11 of an over-long frame, dropping short frames and edges sent while deselected, and holding the write until deselect.

// File: rtl/ser_dac_load.sv
module ser_dac_load #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               mid_rst,
  input  logic                               shdn,
  input  logic                               sclk,
  input  logic                               cs_n,
  input  logic                               sdi,
  output logic [(1<<ADDR_W)*DATA_W-1:0]      levels,
  output logic                               shdn_o,
  output logic                               wr_stb,
  output logic [ADDR_W-1:0]                  wr_addr
);
  localparam int NREG  = 1 << ADDR_W;
  localparam int FRAME = ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(FRAME + 1);
  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

  logic [2:0] sc_q, cs_q;
  logic [1:0] sd_q;
  logic [FRAME-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DATA_W-1:0] store_q [NREG];
  logic [NREG*DATA_W-1:0] store_flat;
  logic shdn_q;

  wire sc_rise = sc_q[1] & ~sc_q[2] & ~cs_q[1];
  wire cs_rise = cs_q[1] & ~cs_q[2];
  wire full    = (cnt_q == CNT_W'(FRAME));
  wire [ADDR_W-1:0] sel = sh_q[FRAME-1 -: ADDR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q    <= '0;
      cs_q    <= '1;
      sd_q    <= '0;
      sh_q    <= '0;
      cnt_q   <= '0;
      shdn_q  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      for (int i = 0; i < NREG; i++) store_q[i] <= MID;
    end else begin
      sc_q   <= {sc_q[1:0], sclk};
      cs_q   <= {cs_q[1:0], cs_n};
      sd_q   <= {sd_q[0], sdi};
      shdn_q <= shdn;
      wr_stb <= 1'b0;
      if (cs_q[1]) begin
        sh_q  <= '0;
        cnt_q <= '0;
      end else if (sc_rise) begin
        sh_q <= {sh_q[FRAME-2:0], sd_q[1]};
        if (!full) cnt_q <= cnt_q + 1'b1;
      end
      if (mid_rst) begin
        for (int i = 0; i < NREG; i++) store_q[i] <= MID;
      end else if (cs_rise && full) begin
        store_q[sel] <= sh_q[DATA_W-1:0];
        wr_stb       <= 1'b1;
        wr_addr      <= sel;
      end
    end
  end

  for (genvar k = 0; k < NREG; k++) begin : g_out
    assign store_flat[k*DATA_W +: DATA_W] = store_q[k];
  end

  assign levels = shdn_q ? '0 : store_flat;
  assign shdn_o = shdn_q;
endmodule

module ser_dac_load_chk #(
  parameter int NREG   = 8,
  parameter int DATA_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   mid_rst,
  input logic                   shdn_o,
  input logic                   wr_stb,
  input logic [NREG*DATA_W-1:0] levels,
  input logic [NREG*DATA_W-1:0] store_flat
);
  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

  // R6
  store_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && !$past(mid_rst)) |-> $stable(store_flat));
  // R7
  preset_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mid_rst |=> (store_flat == {NREG{MID}}));
  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  // R8
  shdn_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_o |-> (levels == '0));
endmodule

bind ser_dac_load ser_dac_load_chk #(.NREG(NREG), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mid_rst(mid_rst), .shdn_o(shdn_o),
  .wr_stb(wr_stb), .levels(levels), .store_flat(store_flat)
);

// File: tb/ser_dac_load_test.sv
module ser_dac_load_test;
  logic clk = 0, rst_n = 0, mid_rst = 0, shdn = 0, sclk = 0, cs_n = 1, sdi = 0;
  logic [63:0] levels;
  logic shdn_o, wr_stb;
  logic [2:0] wr_addr;
  int n_run = 0, n_fail = 0, stb_n = 0;
  logic [2:0] stb_addr;
  logic [7:0] mdl [8];

  always #2 clk = ~clk;

  ser_dac_load uut (.clk, .rst_n, .mid_rst, .shdn, .sclk, .cs_n, .sdi,
                    .levels, .shdn_o, .wr_stb, .wr_addr);

  always @(negedge clk) if (wr_stb) begin stb_n++; stb_addr = wr_addr; end

  localparam logic [10:0] VEC [8] = '{
    {3'd0, 8'h11}, {3'd5, 8'hA5}, {3'd7, 8'hFF}, {3'd2, 8'h00},
    {3'd0, 8'h3C}, {3'd3, 8'h81}, {3'd6, 8'h5A}, {3'd1, 8'hC3}};

  function automatic logic [63:0] flat();
    logic [63:0] f;
    for (int k = 0; k < 8; k++) f[k*8 +: 8] = mdl[k];
    return f;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = w[i];
      repeat (4) @(negedge clk);
      sclk = 1;
      repeat (4) @(negedge clk);
      sclk = 0;
    end
  endtask

  task automatic frame(input logic [31:0] w, input int n);
    @(negedge clk); cs_n = 0; stb_n = 0;
    repeat (4) @(negedge clk);
    bits(w, n);
    repeat (4) @(negedge clk);
    cs_n = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 8; k++) mdl[k] = 8'h80;
    repeat (3) @(negedge clk);
    chk("R7 reset levels", levels, flat());
    chk("R9 reset strobe", {63'd0, wr_stb}, 64'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    foreach (VEC[i]) begin
      frame({21'd0, VEC[i]}, 11);
      mdl[VEC[i][10:8]] = VEC[i][7:0];
      chk("R1 R2 vector load", levels, flat());
      chk("R9 strobe count", stb_n, 1);
      chk("R9 strobe addr", stb_addr, VEC[i][10:8]);
    end

    frame({18'd0, 3'b101, 3'd4, 8'h77}, 14);
    mdl[4] = 8'h77;
    chk("R3 14-bit frame", levels, flat());
    frame({10'd0, 11'h7FF, 3'd6, 8'h29}, 22);
    mdl[6] = 8'h29;
    chk("R3 22-bit frame", levels, flat());

    frame({22'd0, 3'd2, 7'h55}, 10);
    chk("R4 10-bit frame", levels, flat());
    chk("R4 no strobe", stb_n, 0);
    frame(32'd0, 0);
    chk("R4 empty frame", stb_n, 0);

    stb_n = 0;
    bits({21'd0, 3'd5, 8'h00}, 11);
    repeat (8) @(negedge clk);
    chk("R5 edges while deselected", levels, flat());
    chk("R5 no strobe", stb_n, 0);
    frame({27'd0, 5'b11111}, 5);
    frame({21'd0, 3'd1, 8'h6E}, 11);
    mdl[1] = 8'h6E;
    chk("R5 cleared partial frame", levels, flat());

    @(negedge clk); cs_n = 0; stb_n = 0;
    repeat (4) @(negedge clk);
    bits({21'd0, 3'd3, 8'h0F}, 11);
    repeat (12) @(negedge clk);
    chk("R6 held until deselect", levels, flat());
    cs_n = 1;
    repeat (8) @(negedge clk);
    mdl[3] = 8'h0F;
    chk("R6 written after deselect", levels, flat());

    shdn = 1;
    @(negedge clk);
    chk("R8 shdn_o raised", {63'd0, shdn_o}, 64'd1);
    chk("R8 outputs zero", levels, 64'd0);
    frame({21'd0, 3'd7, 8'h42}, 11);
    mdl[7] = 8'h42;
    chk("R8 zero while loading", levels, 64'd0);
    shdn = 0;
    repeat (2) @(negedge clk);
    chk("R8 levels restored", levels, flat());
    chk("R8 shdn_o low", {63'd0, shdn_o}, 64'd0);

    mid_rst = 1;
    @(negedge clk);
    mid_rst = 0;
    @(negedge clk);
    for (int k = 0; k < 8; k++) mdl[k] = 8'h80;
    chk("R7 mid preset", levels, flat());

    frame({21'd0, 3'd2, 8'hEE}, 11);
    mdl[2] = 8'hEE;
    rst_n = 0;
    @(negedge clk);
    for (int k = 0; k < 8; k++) mdl[k] = 8'h80;
    chk("R7 async reset", levels, flat());
    rst_n = 1;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule